// File: doc/BRIEF.md
# Bus Acknowledge Timeout and Retry Unit

This unit sits between a processor core and its memory bus. It watches every bus operation that the core launches for a missing acknowledge. The core hands over one operation with a single-cycle start strobe, along with the address, write data, write enable and byte enables. The unit captures these attributes and drives the request line with them until the memory returns an acknowledge. If no acknowledge arrives within a window sized for slow DRAM, the unit abandons the attempt. It drops the request for one cycle, signals a re-issue and presents the same operation again. The core therefore survives a lost acknowledge pulse instead of stalling forever.

The retry budget is limited. When the last permitted retry also runs out of time, the unit stops retrying. It emits a one-cycle bus-error pulse to the core and keeps the faulting address on a register output. That address stays valid until the core starts its next operation. The start strobe is not a valid/ready stream. The core may launch only while `busy` is low, and a strobe given while `busy` is high has no effect. There is no back-pressure beyond that rule. The acknowledge is a plain input that counts only while the request line is high.

Top module: `bus_ack_watchdog`

## Requirements
- R1: During and right after reset, `bus_req`, `busy`, `retry_pulse` and `berr_pulse` are 0 and `berr_addr` is 0.
- R2: A start strobe while `busy` is 0 captures the attributes. On the next cycle `bus_req` is 1 and `bus_addr`, `bus_wdata`, `bus_we` and `bus_be` equal the captured values. They stay equal through every attempt of that operation.
- R3: An acknowledge seen in a cycle with `bus_req` high ends the operation. On the next cycle `bus_req`, `busy`, `retry_pulse` and `berr_pulse` are all 0.
- R4: If `bus_req` has been high for TIMEOUT (default 256) cycles with no acknowledge and retries remain, the next cycle has `bus_req` at 0 and `retry_pulse` at 1 for exactly one cycle. The cycle after that has `bus_req` at 1 again.
- R5: An operation makes at most MAX_RETRY (default 4) retries. If attempt MAX_RETRY+1 also times out, the next cycle has `berr_pulse` at 1 and `bus_req` at 0 for one cycle. In that cycle `berr_addr` equals the operation's address. The unit is idle the cycle after.
- R6: An acknowledge in any attempt, including the last permitted one, completes the operation without a bus error. The next operation again gets the full MAX_RETRY retries.
- R7: An acknowledge while `bus_req` is 0 has no effect. This holds while idle and in the gap cycle of a retry. It starts no operation, shortens no attempt and ends no operation.
- R8: A start strobe while `busy` is 1 is ignored, and the presented attributes do not change.
- R9: `berr_addr` holds its value while idle and reads 0 from the first cycle of the next accepted operation.
- R10: The timeout count restarts at zero for every attempt. Every attempt that times out keeps `bus_req` high for exactly TIMEOUT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_start | input | 1 | One-cycle launch strobe from the core |
| core_addr | input | AW | Operation address |
| core_wdata | input | DW | Write data |
| core_we | input | 1 | Write enable (1 = write) |
| core_be | input | DW/8 | Byte enables |
| bus_ack | input | 1 | Acknowledge from the bus |
| busy | output | 1 | Operation in progress; start accepted only when 0 |
| bus_req | output | 1 | Request valid toward the bus |
| bus_addr | output | AW | Presented address |
| bus_wdata | output | DW | Presented write data |
| bus_we | output | 1 | Presented write enable |
| bus_be | output | DW/8 | Presented byte enables |
| retry_pulse | output | 1 | One-cycle re-issue strobe, in the gap cycle |
| berr_pulse | output | 1 | One-cycle bus-error exception |
| berr_addr | output | AW | Address of the last failed operation |

## Verification
The bench places the acknowledge at the first cycle of an attempt and at its last counted cycle. An off-by-one timer would either retry an operation that was acknowledged in time or wait one cycle too long. It puts the acknowledge in the last permitted attempt and then runs a fully failing operation. A retry counter that is not cleared, or one that stops one retry early or late, would raise the bus error too soon or too late. It also pulses the acknowledge in the retry gap and while idle, and strobes start during an operation. A design that honours either would cut an attempt short, finish early, or change the presented address.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GAP   = 2'd2,
    ST_FAULT = 2'd3
  } bat_state_t;
endpackage

// File: rtl/bat_timer.sv
module bat_timer #(
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
    else                       cnt <= '0;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/bat_tries.sv
module bat_tries #(
  parameter int MAX_RETRY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int RW = $clog2(MAX_RETRY + 1) > 0 ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

  logic [RW-1:0] tries;

  always_ff @(posedge clk) begin
    if (!rst_n)     tries <= '0;
    else if (clr)   tries <= '0;
    else if (inc)   tries <= tries + 1'b1;
  end

  assign exhausted = (tries == LIMIT);
endmodule

// File: rtl/bat_hold.sv
module bat_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog
  import bat_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int TIMEOUT   = 256,
  parameter int MAX_RETRY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_start,
  input  logic [AW-1:0]     core_addr,
  input  logic [DW-1:0]     core_wdata,
  input  logic              core_we,
  input  logic [DW/8-1:0]   core_be,
  input  logic              bus_ack,
  output logic              busy,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_we,
  output logic [DW/8-1:0]   bus_be,
  output logic              retry_pulse,
  output logic              berr_pulse,
  output logic [AW-1:0]     berr_addr
);
  localparam int BW     = DW / 8;
  localparam int ATTR_W = AW + DW + 1 + BW;

  bat_state_t state, state_nx;
  logic accept, expired, exhausted, give_up, do_retry;
  logic [ATTR_W-1:0] attr_in, attr_q;

  assign accept   = (state == ST_IDLE) && core_start;
  assign give_up  = (state == ST_WAIT) && !bus_ack && expired && exhausted;
  assign do_retry = (state == ST_WAIT) && !bus_ack && expired && !exhausted;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (core_start) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (bus_ack)      state_nx = ST_IDLE;
        else if (give_up) state_nx = ST_FAULT;
        else if (do_retry) state_nx = ST_GAP;
      end
      ST_GAP:   state_nx = ST_WAIT;
      ST_FAULT: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  bat_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_WAIT),
    .expired (expired)
  );

  bat_tries #(.MAX_RETRY(MAX_RETRY)) u_tries (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .inc       (do_retry),
    .exhausted (exhausted)
  );

  assign attr_in = {core_addr, core_wdata, core_we, core_be};

  bat_hold #(.W(ATTR_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (attr_in),
    .dout  (attr_q)
  );

  assign {bus_addr, bus_wdata, bus_we, bus_be} = attr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       berr_addr <= '0;
    else if (accept)  berr_addr <= '0;
    else if (give_up) berr_addr <= bus_addr;
  end

  assign busy        = (state != ST_IDLE);
  assign bus_req     = (state == ST_WAIT);
  assign retry_pulse = (state == ST_GAP);
  assign berr_pulse  = (state == ST_FAULT);
endmodule

// File: rtl/bat_checker.sv
module bat_checker #(
  parameter int AW        = 32,
  parameter int TIMEOUT   = 256,
  parameter int MAX_RETRY = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_start,
  input logic          bus_ack,
  input logic          busy,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          retry_pulse,
  input logic          berr_pulse,
  input logic [AW-1:0] berr_addr
);
  localparam int RUNW = $clog2(TIMEOUT + 2);
  localparam int RTW  = $clog2(MAX_RETRY + 2);

  logic [RUNW-1:0] req_run;
  logic [RTW-1:0]  rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       req_run <= '0;
    else if (bus_req) req_run <= req_run + 1'b1;
    else              req_run <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    rcnt <= '0;
    else if (core_start && !busy)  rcnt <= '0;
    else if (retry_pulse)          rcnt <= rcnt + 1'b1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !busy) |=> bus_req);
  p_attr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));
  p_ack_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> (!busy && !retry_pulse && !berr_pulse));
  p_gap_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> !bus_req);
  p_gap_reissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> bus_req);
  p_retry_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= RTW'(MAX_RETRY));
  p_berr_after_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |-> (rcnt == RTW'(MAX_RETRY)));
  p_berr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |=> (!berr_pulse && !busy));
  p_strobes_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_req, retry_pulse, berr_pulse}));
  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !core_start && bus_ack) |=> !busy);
  p_berr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !busy) |=> (berr_addr == '0));
  p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_run <= RUNW'(TIMEOUT));
endmodule

bind bus_ack_watchdog bat_checker #(
  .AW(AW), .TIMEOUT(TIMEOUT), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_start  (core_start),
  .bus_ack     (bus_ack),
  .busy        (busy),
  .bus_req     (bus_req),
  .bus_addr    (bus_addr),
  .retry_pulse (retry_pulse),
  .berr_pulse  (berr_pulse),
  .berr_addr   (berr_addr)
);

// File: tb/bus_ack_watchdog_test.sv
module bus_ack_watchdog_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int T  = 256;
  localparam int M  = 4;
  localparam int NEVER = M + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_start = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_we = 1'b0;
  logic [DW/8-1:0] core_be = '0;
  logic bus_ack = 1'b0;
  logic busy, bus_req, bus_we, retry_pulse, berr_pulse;
  logic [AW-1:0] bus_addr, berr_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW/8-1:0] bus_be;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bus_ack_watchdog #(.AW(AW), .DW(DW), .TIMEOUT(T), .MAX_RETRY(M)) uut (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_we(core_we), .core_be(core_be),
    .bus_ack(bus_ack), .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_be(bus_be),
    .retry_pulse(retry_pulse), .berr_pulse(berr_pulse), .berr_addr(berr_addr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_retries(input int ack_att);
    return (ack_att > M) ? M : ack_att;
  endfunction

  function automatic bit exp_berr(input int ack_att);
    return ack_att > M;
  endfunction

  // One operation: ack in attempt ack_att (NEVER = none) at cycle ack_dly of it.
  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int ack_att, input int ack_dly,
                        input bit gap_ack, input bit busy_start);
    int attempt = 0;
    int c = 0;
    int retries = 0;
    bit berr_seen = 0;
    bit last_ack = 0;
    bit done = 0;
    bit attr_bad = 0;
    bit len_bad = 0;
    logic [DW/8-1:0] be = DW/8'($urandom);
    logic we = 1'($urandom);
    @(negedge clk);
    core_start = 1'b1; core_addr = a; core_wdata = d; core_we = we; core_be = be;
    @(negedge clk);
    core_start = 1'b0;
    check(bus_req === 1'b1, "R2 bus_req after start", bus_req, 1);
    check(berr_addr === '0, "R9 berr_addr cleared at start", berr_addr, 0);
    for (int i = 0; i < 2000 && !done; i++) begin
      if (bus_req) begin
        if (last_ack) begin
          check(0, "R3 bus_req after ack", bus_req, 0);
          done = 1;
        end
        if (bus_addr !== a || bus_wdata !== d || bus_we !== we || bus_be !== be) attr_bad = 1;
        if (attempt == ack_att && c == ack_dly) begin bus_ack = 1'b1; last_ack = 1; end
        else bus_ack = 1'b0;
        if (busy_start && attempt == 0 && c == 5) begin
          core_start = 1'b1; core_addr = ~a; core_wdata = ~d; core_we = ~we; core_be = ~be;
        end else core_start = 1'b0;
        c++;
      end else begin
        bus_ack = 1'b0; core_start = 1'b0;
        if (retry_pulse) begin
          if (c != T) len_bad = 1;
          retries++; attempt++; c = 0;
          if (gap_ack) bus_ack = 1'b1;
        end else if (berr_pulse) begin
          if (c != T) len_bad = 1;
          berr_seen = 1;
          check(berr_addr === a, "R5 berr_addr", berr_addr, a);
          done = 1;
        end else if (last_ack) begin
          check(!busy && !retry_pulse, "R3 idle after ack", busy, 0);
          done = 1;
        end else begin
          check(0, "R4 unexpected drop of bus_req", bus_req, 1);
          done = 1;
        end
      end
      @(negedge clk);
    end
    bus_ack = 1'b0; core_start = 1'b0;
    check(retries == exp_retries(ack_att), "R4/R6 retry count", retries, exp_retries(ack_att));
    check(berr_seen == exp_berr(ack_att), "R5 bus error", berr_seen, exp_berr(ack_att));
    check(!len_bad, "R10 attempt length", len_bad, 0);
    check(!attr_bad, busy_start ? "R8 attrs under busy start" : "R2 attrs stable", attr_bad, 0);
    check(busy === 1'b0, "R3 busy low after op", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!bus_req && !busy && !retry_pulse && !berr_pulse && berr_addr == '0,
          "R1 reset outputs", {bus_req, busy, retry_pulse, berr_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !busy, "R1 after reset", {bus_req, busy}, 0);

    // R7: ack while idle is ignored
    bus_ack = 1'b1;
    repeat (3) @(negedge clk);
    bus_ack = 1'b0;
    @(negedge clk);
    check(!bus_req && !busy && !berr_pulse && !retry_pulse, "R7 idle ack",
          {bus_req, busy, berr_pulse, retry_pulse}, 0);

    // Directed corners
    run_op(32'h1000_0040, 32'hA5A5_0001, 0, 0, 0, 0);        // R3 immediate ack
    run_op(32'h1000_0080, 32'hA5A5_0002, 0, T - 1, 0, 0);    // R10 ack at last cycle
    run_op(32'h1000_00C0, 32'hA5A5_0003, 1, 0, 1, 0);        // R7 gap ack ignored
    run_op(32'h1000_0100, 32'hA5A5_0004, M, T - 1, 0, 0);    // R6 last attempt ack
    run_op(32'hDEAD_BEE0, 32'hA5A5_0005, NEVER, 0, 1, 1);    // R5 full failure, R8
    // R9: fault address held while idle
    repeat (4) @(negedge clk);
    check(berr_addr === 32'hDEAD_BEE0, "R9 berr_addr held", berr_addr, 32'hDEAD_BEE0);
    run_op(32'h2000_0000, 32'hA5A5_0006, NEVER, 0, 0, 0);    // R6 full budget again

    // Constrained random
    for (int k = 0; k < 24; k++) begin
      int att = $urandom_range(NEVER, 0);
      int dly = ($urandom_range(3, 0) == 0) ? T - 1 : $urandom_range(T - 1, 0);
      run_op($urandom, $urandom, att, dly, 1'($urandom), 1'($urandom));
      repeat ($urandom_range(3, 0)) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule